// File: doc/BRIEF.md
# Smart-Card Character Waiting-Time Watchdog

This block watches the I/O line of a smart-card interface and reports when the card has stayed silent for too long. It runs on the card clock. A prescaler splits the card clock into chunks of twelve elementary time units (ETUs), and a chunk counter compares the number of completed chunks with a limit derived from the negotiated waiting time. When half of that limit has passed, the block gives a one-cycle warning pulse. When all of it has passed, it gives a one-cycle timeout pulse and then holds still.

Every falling edge on the I/O line marks activity from the card. It restarts the measurement from zero and re-arms a watchdog that has already timed out. Two configuration inputs, each with its own write strobe, set the waiting time in ETUs and the number of card clocks per ETU. Two pulse inputs start and stop the measurement. An auxiliary square-wave output marks the middle and the end of each chunk.

Top module: `card_wait_timer`

## Requirements
- R1: After reset the block is stopped and all three outputs are low. Clocks per ETU resets to 372 and the waiting time resets to 9600 ETUs. After a start with these defaults, the auxiliary output first goes high 2233 cycles after the start edge.
- R2: The chunk compare value is clocks_per_etu × 12. While running, the prescaler counts up from 0. In the cycle where it has reached the compare value (or gone past it), it produces a chunk tick and returns to 0. A chunk therefore lasts compare value + 1 cycles.
- R3: The chunk limit is waiting_time / 12, rounded down. It is recomputed from the current values of both settings whenever either write strobe is high. A write to one setting keeps the stored value of the other.
- R4: The I/O line passes through a two-flop synchronizer. A falling edge is a synchronized 1 followed by a synchronized 0. The clock edge after detection clears the chunk count and the prescaler, 3 edges after the line drops. An edge that lands in the same cycle as a chunk tick wins, and that tick is not counted.
- R5: When the chunk count becomes exactly limit / 2, rounded down, and that value is below the limit, half_pulse is high for exactly one cycle. half_pulse and exp_pulse are never high together.
- R6: When a tick brings the chunk count to the limit or above it, exp_pulse is high for one cycle, on the edge that completes chunk number "limit". The prescaler and the count then stay frozen until the next falling edge or start. A limit of zero expires on the first tick and gives no half pulse.
- R7: start clears the chunk count, clears the frozen state and runs the prescaler from 0. It takes effect on the edge where it is sampled, and stop has priority over start.
- R8: stop clears the chunk count and halts the prescaler. While stopped, no half or timeout pulse occurs.
- R9: aux_out goes high in the cycle after the prescaler equals compare/2 (rounded down). It goes low on the chunk tick, and it goes low on start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_line | input | 1 | Card I/O line, asynchronous |
| wt_we | input | 1 | Write strobe for the waiting time |
| wt_val | input | 16 | Waiting time in ETUs |
| etu_we | input | 1 | Write strobe for clocks per ETU |
| etu_val | input | 16 | Card clocks per ETU |
| start | input | 1 | Pulse: clear and start measuring |
| stop | input | 1 | Pulse: clear and halt |
| half_pulse | output | 1 | Half of the waiting time elapsed |
| exp_pulse | output | 1 | Waiting time elapsed |
| aux_out | output | 1 | Chunk-phase square wave |

## Verification
The hardest case to reach from the ports is a falling edge on the I/O line whose detection lands in exactly the cycle where the prescaler wraps. The synchronizer hides the timing of the edge, so the stimulus counts the start edge and the synchronizer latency. It drops the line three edges before the wrap, so that the clear and the tick meet in the same cycle. It then checks that the timeout comes a full limit of chunks later, not one chunk earlier. A zero and a one-chunk limit, odd limits, and a rounded-down waiting time exercise the half-pulse corner cases.

// File: rtl/cwt_pkg.sv
package cwt_pkg;

   // Control command for one cycle, decoded in priority order in the top
   typedef enum logic [1:0] {
      CMD_IDLE  = 2'd0,
      CMD_START = 2'd1,
      CMD_STOP  = 2'd2,
      CMD_REARM = 2'd3
   } cwt_cmd_e;

   function automatic logic cmd_clears(input cwt_cmd_e c);
      return c != CMD_IDLE;
   endfunction

endpackage

// File: rtl/cwt_sync_fall.sv
module cwt_sync_fall #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic fall_o
);
   // sh[0..STAGES-1] is the synchronizer chain, sh[STAGES] holds the previous value
   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh[0] <= 1'b1;
      else        sh[0] <= line_i;
   end

   for (genvar i = 1; i <= STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh[i] <= 1'b1;
         else        sh[i] <= sh[i-1];
      end
   end

   assign fall_o = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/cwt_cfg.sv
module cwt_cfg #(
   parameter int unsigned WT_W       = 16,
   parameter int unsigned ETU_W      = 16,
   parameter int unsigned PER_W      = 20,
   parameter int unsigned CHUNK_ETUS = 12,
   parameter int unsigned DEF_WAIT   = 9600,
   parameter int unsigned DEF_ETU    = 372
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wt_we,
   input  logic [WT_W-1:0]  wt_val,
   input  logic             etu_we,
   input  logic [ETU_W-1:0] etu_val,
   output logic [WT_W-1:0]  limit_o,
   output logic [PER_W-1:0] period_o
);
   localparam logic [WT_W-1:0]  WT_RST    = WT_W'(DEF_WAIT);
   localparam logic [ETU_W-1:0] ETU_RST   = ETU_W'(DEF_ETU);
   localparam logic [WT_W-1:0]  LIMIT_RST = WT_W'(DEF_WAIT / CHUNK_ETUS);
   localparam logic [PER_W-1:0] PER_RST   = PER_W'(DEF_ETU * CHUNK_ETUS);
   localparam logic [WT_W-1:0]  DIV_K     = WT_W'(CHUNK_ETUS);
   localparam logic [PER_W-1:0] MUL_K     = PER_W'(CHUNK_ETUS);

   logic [WT_W-1:0]  wt_q, wt_nxt;
   logic [ETU_W-1:0] etu_q, etu_nxt;

   assign wt_nxt  = wt_we  ? wt_val  : wt_q;
   assign etu_nxt = etu_we ? etu_val : etu_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wt_q     <= WT_RST;
         etu_q    <= ETU_RST;
         limit_o  <= LIMIT_RST;
         period_o <= PER_RST;
      end else if (wt_we || etu_we) begin
         wt_q     <= wt_nxt;
         etu_q    <= etu_nxt;
         limit_o  <= wt_nxt / DIV_K;
         period_o <= PER_W'(etu_nxt) * MUL_K;
      end
   end
endmodule

// File: rtl/cwt_prescaler.sv
module cwt_prescaler
   import cwt_pkg::*;
#(
   parameter int unsigned PER_W  = 20,
   parameter bit          AUX_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cwt_cmd_e         cmd,
   input  logic             active,
   input  logic [PER_W-1:0] period,
   output logic             tick_o,
   output logic [PER_W-1:0] count_o,
   output logic             aux_o
);
   logic [PER_W-1:0] cnt_q;
   logic             at_top, at_mid, idle;

   assign idle    = (cmd == CMD_IDLE);
   assign at_top  = (cnt_q >= period);
   assign at_mid  = (cnt_q == (period >> 1));
   assign tick_o  = idle && active && at_top;
   assign count_o = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (cmd_clears(cmd)) cnt_q <= '0;
      else if (active)          cnt_q <= at_top ? '0 : cnt_q + 1'b1;
   end

   if (AUX_EN) begin : g_aux
      logic aux_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           aux_q <= 1'b0;
         else if (cmd == CMD_START)            aux_q <= 1'b0;
         else if (tick_o)                      aux_q <= 1'b0;
         else if (idle && active && at_mid)    aux_q <= 1'b1;
      end
      assign aux_o = aux_q;
   end else begin : g_no_aux
      assign aux_o = 1'b0;
   end
endmodule

// File: rtl/cwt_tick_cnt.sv
module cwt_tick_cnt
   import cwt_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cwt_cmd_e         cmd,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             half_o,
   output logic             exp_o,
   output logic             frozen_o
);
   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             hit_half, hit_end;

   assign cnt_nxt  = cnt_q + 1'b1;
   assign hit_end  = (cnt_nxt >= limit);
   assign hit_half = (cnt_nxt == (limit >> 1)) && !hit_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         half_o   <= 1'b0;
         exp_o    <= 1'b0;
         frozen_o <= 1'b0;
      end else if (cmd_clears(cmd)) begin
         cnt_q    <= '0;
         half_o   <= 1'b0;
         exp_o    <= 1'b0;
         frozen_o <= 1'b0;
      end else if (tick) begin
         cnt_q    <= cnt_nxt;
         half_o   <= hit_half;
         exp_o    <= hit_end;
         frozen_o <= hit_end;
      end else begin
         half_o   <= 1'b0;
         exp_o    <= 1'b0;
      end
   end
endmodule

// File: rtl/card_wait_timer.sv
module card_wait_timer
   import cwt_pkg::*;
#(
   parameter int unsigned WT_W        = 16,
   parameter int unsigned ETU_W       = 16,
   parameter int unsigned CHUNK_ETUS  = 12,
   parameter int unsigned DEF_WAIT    = 9600,
   parameter int unsigned DEF_ETU     = 372,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          AUX_EN      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             io_line,
   input  logic             wt_we,
   input  logic [WT_W-1:0]  wt_val,
   input  logic             etu_we,
   input  logic [ETU_W-1:0] etu_val,
   input  logic             start,
   input  logic             stop,
   output logic             half_pulse,
   output logic             exp_pulse,
   output logic             aux_out
);
   localparam int unsigned PER_W = ETU_W + $clog2(CHUNK_ETUS);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("card_wait_timer: SYNC_STAGES must be at least 2");
   end
   if (CHUNK_ETUS < 2) begin : g_bad_chunk
      $error("card_wait_timer: CHUNK_ETUS must be at least 2");
   end
   if (DEF_WAIT >= (64'd1 << WT_W)) begin : g_bad_wait
      $error("card_wait_timer: DEF_WAIT does not fit WT_W");
   end
   if (DEF_ETU >= (64'd1 << ETU_W)) begin : g_bad_etu
      $error("card_wait_timer: DEF_ETU does not fit ETU_W");
   end

   logic             io_fall;
   logic [WT_W-1:0]  limit;
   logic [PER_W-1:0] period;
   logic [PER_W-1:0] presc_cnt;
   logic             run_q, frozen, active, tick;
   cwt_cmd_e         cmd;

   cwt_sync_fall #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (io_line),
      .fall_o (io_fall)
   );

   cwt_cfg #(
      .WT_W       (WT_W),
      .ETU_W      (ETU_W),
      .PER_W      (PER_W),
      .CHUNK_ETUS (CHUNK_ETUS),
      .DEF_WAIT   (DEF_WAIT),
      .DEF_ETU    (DEF_ETU)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wt_we    (wt_we),
      .wt_val   (wt_val),
      .etu_we   (etu_we),
      .etu_val  (etu_val),
      .limit_o  (limit),
      .period_o (period)
   );

   // Priority: stop, then start, then I/O activity
   always_comb begin
      if (stop)         cmd = CMD_STOP;
      else if (start)   cmd = CMD_START;
      else if (io_fall) cmd = CMD_REARM;
      else              cmd = CMD_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 run_q <= 1'b0;
      else if (cmd == CMD_STOP)   run_q <= 1'b0;
      else if (cmd == CMD_START)  run_q <= 1'b1;
   end

   assign active = run_q && !frozen;

   cwt_prescaler #(.PER_W(PER_W), .AUX_EN(AUX_EN)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd),
      .active  (active),
      .period  (period),
      .tick_o  (tick),
      .count_o (presc_cnt),
      .aux_o   (aux_out)
   );

   cwt_tick_cnt #(.CNT_W(WT_W)) u_ticks (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .tick     (tick),
      .limit    (limit),
      .half_o   (half_pulse),
      .exp_o    (exp_pulse),
      .frozen_o (frozen)
   );
endmodule

// File: rtl/cwt_checker.sv
module cwt_checker #(
   parameter int unsigned PER_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             stop,
   input logic             fall,
   input logic             run,
   input logic [PER_W-1:0] presc,
   input logic             half,
   input logic             expd,
   input logic             aux
);
   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(half && expd));                                             // R5
   AST_HALF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      half |=> !half);                                              // R5
   AST_EXP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      expd |=> !expd);                                              // R6
   AST_EXP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      expd |-> (presc == '0));                                      // R6
   AST_FALL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && !start && !stop) |=> (presc == '0));                 // R4
   AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (!half && !expd));                                   // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !start) |=> (!half && !expd));                       // R8
   AST_AUX_START: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !stop) |=> !aux);                                   // R9
endmodule

bind card_wait_timer cwt_checker #(.PER_W(PER_W)) u_cwt_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .stop  (stop),
   .fall  (io_fall),
   .run   (run_q),
   .presc (presc_cnt),
   .half  (half_pulse),
   .expd  (exp_pulse),
   .aux   (aux_out)
);

// File: tb/tb_card_wait_timer.sv
`timescale 1ns/1ps
module tb_card_wait_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_line = 1'b1;
   logic        wt_we = 1'b0;
   logic [15:0] wt_val = '0;
   logic        etu_we = 1'b0;
   logic [15:0] etu_val = '0;
   logic        start = 1'b0;
   logic        stop = 1'b0;
   logic        half_pulse, exp_pulse, aux_out;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   card_wait_timer dut (
      .clk(clk), .rst_n(rst_n), .io_line(io_line),
      .wt_we(wt_we), .wt_val(wt_val), .etu_we(etu_we), .etu_val(etu_val),
      .start(start), .stop(stop),
      .half_pulse(half_pulse), .exp_pulse(exp_pulse), .aux_out(aux_out)
   );

   task automatic chk(input string req, input string what, input int act, input int expv);
      n_chk++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); @(negedge clk);
      end
   endtask

   task automatic do_start();
      start = 1'b1; @(posedge clk); @(negedge clk); start = 1'b0;
   endtask

   task automatic do_stop();
      stop = 1'b1; @(posedge clk); @(negedge clk); stop = 1'b0;
   endtask

   task automatic wr_both(input int wt, input int etu);
      wt_we = 1'b1; wt_val = 16'(wt); etu_we = 1'b1; etu_val = 16'(etu);
      step(1);
      wt_we = 1'b0; etu_we = 1'b0;
   endtask

   task automatic wr_wt(input int wt);
      wt_we = 1'b1; wt_val = 16'(wt); step(1); wt_we = 1'b0;
   endtask

   // Counts edges from the call; records the first pulse positions and totals
   task automatic measure(input int ncyc, output int k_half, output int k_exp,
                          output int n_half, output int n_exp);
      k_half = -1; k_exp = -1; n_half = 0; n_exp = 0;
      for (int k = 1; k <= ncyc; k++) begin
         @(posedge clk); @(negedge clk);
         if (half_pulse) begin n_half++; if (k_half < 0) k_half = k; end
         if (exp_pulse)  begin n_exp++;  if (k_exp < 0)  k_exp = k;  end
      end
   endtask

   // Standard run: start, then expect half and expiry at given edges
   task automatic run_limit(input string req, input int cyc, input int e_half, input int e_exp, input int e_nhalf);
      int kh, ke, nh, ne;
      do_start();
      measure(cyc, kh, ke, nh, ne);
      chk(req, "expiry edge", ke, e_exp);
      chk(req, "expiry count", ne, 1);
      chk(req, "half count", nh, e_nhalf);
      if (e_nhalf > 0) chk(req, "half edge", kh, e_half);
      do_stop();
   endtask

   task automatic t_reset();
      int kh, ke, nh, ne;
      chk("R1", "half after reset", int'(half_pulse), 0);
      chk("R1", "exp after reset", int'(exp_pulse), 0);
      chk("R1", "aux after reset", int'(aux_out), 0);
      step(20);
      chk("R1", "aux idle without start", int'(aux_out), 0);
      do_start();
      measure(2232, kh, ke, nh, ne);
      chk("R1", "aux before default mid point", int'(aux_out), 0);
      step(1);
      chk("R1", "aux at default mid point", int'(aux_out), 1);
      chk("R1", "no pulses early with defaults", nh + ne, 0);
      do_stop();
   endtask

   task automatic t_basic_and_freeze();
      int kh, ke, nh, ne;
      wr_both(48, 1);                 // R2 compare 12, R3 limit 4
      do_start();
      measure(200, kh, ke, nh, ne);
      chk("R2", "expiry edge, 4 chunks of 13", ke, 52);
      chk("R5", "half edge at 2 chunks", kh, 26);
      chk("R5", "single half pulse", nh, 1);
      chk("R6", "single expiry, frozen after", ne, 1);
      chk("R6", "aux low while frozen", int'(aux_out), 0);
      // re-arm by a falling edge on the I/O line
      io_line = 1'b0;
      measure(80, kh, ke, nh, ne);
      chk("R4", "expiry after falling edge", ke, 55);
      chk("R4", "half after falling edge", kh, 29);
      io_line = 1'b1;
      step(4);
      do_stop();
   endtask

   task automatic t_edge_vs_tick();
      int kh, ke, nh, ne;
      wr_both(48, 1);
      do_start();
      step(10);
      io_line = 1'b0;                 // detected so that the clear meets the tick at edge 13
      measure(100, kh, ke, nh, ne);
      chk("R4", "edge beats tick: expiry", ke, 55);
      chk("R4", "edge beats tick: half", kh, 29);
      io_line = 1'b1;
      step(4);
      do_stop();
   endtask

   task automatic t_limits();
      wr_both(11, 1);  run_limit("R6", 40, 0, 13, 0);    // limit 0
      wr_both(12, 1);  run_limit("R5", 40, 0, 13, 0);    // limit 1, half suppressed
      wr_both(36, 1);  run_limit("R5", 60, 13, 39, 1);   // limit 3, half at 1
      wr_both(59, 1);  run_limit("R3", 80, 26, 52, 1);   // 59/12 rounds to 4
      wr_both(48, 2);  run_limit("R2", 140, 50, 100, 1); // compare 24
      wr_wt(24);       run_limit("R3", 80, 25, 50, 1);   // etu 2 kept, limit 2
   endtask

   task automatic t_stop_start();
      int kh, ke, nh, ne;
      wr_both(48, 1);
      do_start();
      step(20);
      do_stop();
      measure(120, kh, ke, nh, ne);
      chk("R8", "no pulses while stopped", nh + ne, 0);
      do_start();
      measure(60, kh, ke, nh, ne);
      chk("R7", "start clears count", ke, 52);
      do_start();                      // restart from frozen
      measure(60, kh, ke, nh, ne);
      chk("R7", "start clears frozen", ke, 52);
      do_stop();
   endtask

   task automatic t_aux();
      wr_both(48, 1);
      do_start();
      for (int k = 1; k <= 20; k++) begin
         step(1);
         if (k == 6)  chk("R9", "aux low before mid", int'(aux_out), 0);
         if (k == 7)  chk("R9", "aux high after mid", int'(aux_out), 1);
         if (k == 12) chk("R9", "aux still high", int'(aux_out), 1);
         if (k == 13) chk("R9", "aux low at wrap", int'(aux_out), 0);
         if (k == 20) chk("R9", "aux high next chunk", int'(aux_out), 1);
      end
      do_start();
      chk("R9", "aux low on start", int'(aux_out), 0);
      do_stop();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic_and_freeze();
      t_edge_vs_tick();
      t_limits();
      t_stop_start();
      t_aux();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", 100000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule